// File: doc/BRIEF.md
# Capture-Compare Interval Timer

This block is a 16-bit up-counter with its own small register file on a simple word-addressed write/read bus. A single mode word picks where count pulses come from (stopped, every system clock, every sixteenth system clock, or rising edges of an external pin), divides that source by a programmable 8-bit prescaler, and decides what happens when the count reaches the reference word: the counter either wraps to zero or keeps counting, and the timer pin either drops low for one cycle or flips its level.

A second external pin can freeze a copy of the live count on its rising edge, its falling edge or both. Reference matches and captures are recorded as sticky event flags. Software clears a flag by writing a one to it. The interrupt request is high while any flag is set whose interrupt is enabled in the mode word. Both external pins are brought into the clock domain through a two-flop synchroniser before any edge is detected.

Top module: `cap_timer`

## Requirements
- R1: After reset the mode word reads 0x0000, the reference reads 0xFFFF, the capture, count and event words read 0, the timer pin is high and the interrupt is low.
- R2: Word offset 0 reads the mode, 1 the reference, 2 the captured count, 3 the live count and 4 the event flags (bit 1 match, bit 0 capture, other bits 0); offsets 5 to 7 read 0.
- R3: Writes to offset 2 (capture) and offset 3 (live count) change nothing.
- R4: While mode bit 0 is 0 the count, the prescaler and the divide-by-16 phase are held at zero and the timer pin is high; with bit 0 at 1 the timer runs.
- R5: Mode bits 2:1 select the count source: 00 none, 01 every clock, 10 one clock in every 16, 11 each rising edge of the synchronised external clock pin.
- R6: Mode bits 15:8 hold a prescale value P; the count advances once for every P+1 source pulses.
- R7: On a count pulse that finds the count equal to the reference, event bit 1 is set; with mode bit 3 at 1 the count returns to 0, otherwise it advances by one (wrapping at 0xFFFF).
- R8: Mode bit 5 at 0 drives the timer pin low for the one cycle after a match; at 1 the pin changes level after each match.
- R9: Mode bits 7:6 select capture on the synchronised capture pin: 00 none, 01 rising, 10 falling, 11 both edges; a capture copies the live count into the capture word and sets event bit 0.
- R10: Writing offset 4 clears each event bit written as 1; a new event in the same cycle wins over the clear.
- R11: The interrupt is high exactly when event bit 1 is set with mode bit 4 at 1, or event bit 0 is set with mode bits 7:6 non-zero.
- R12: Each external pin passes through two flops; an edge on a pin affects the count or capture on the third rising clock edge after it is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register word offset |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i |
| ext_clk_i | input | 1 | External count source pin |
| cap_i | input | 1 | Capture trigger pin |
| tout_o | output | 1 | Timer output pin |
| irq_o | output | 1 | Interrupt request |

## Verification
The counter is driven from each of its four sources, so a pulse per clock, a pulse per sixteen clocks and slow external edges show whether the source select and divide-by-16 phase are wired correctly. Prescale values of 0, 2 and 3 separate an off-by-one in the divider from a wrong select. A small reference value run in restart and in free-running mode, with both pin behaviours, distinguishes wrap-to-zero from continuing and pulse from toggle, while capture pin edges under each edge code show which edges latch the count and raise the capture flag.

// File: rtl/cap_timer_pkg.sv
package cap_timer_pkg;
  localparam int unsigned OFS_MODE = 0;
  localparam int unsigned OFS_REF  = 1;
  localparam int unsigned OFS_CAP  = 2;
  localparam int unsigned OFS_CNT  = 3;
  localparam int unsigned OFS_EVT  = 4;

  typedef enum logic [1:0] {SRC_STOP, SRC_SYS, SRC_DIV, SRC_PIN} src_e;
  typedef enum logic [1:0] {CAP_OFF, CAP_RISE, CAP_FALL, CAP_BOTH} cap_e;

  // bit order matters: software packs this word
  typedef struct packed {
    logic [7:0] ps;
    cap_e       cap;
    logic       toggle;
    logic       ref_irq;
    logic       restart;
    src_e       src;
    logic       run;
  } mode_t;
endpackage

// File: rtl/tmr_sync.sv
module tmr_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic lvl_o,
  output logic prv_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], d_i};
  end

  assign lvl_o = sh_q[STAGES-1];
  assign prv_o = sh_q[STAGES];
endmodule

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen
  import cap_timer_pkg::*;
#(
  parameter int unsigned PSW = 8,
  parameter int unsigned DIV = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           run_i,
  input  src_e           src_i,
  input  logic [PSW-1:0] ps_i,
  input  logic           pin_rise_i,
  output logic           tick_o
);
  localparam int unsigned DCW = $clog2(DIV);

  logic [DCW-1:0] div_q;
  logic [PSW-1:0] pc_q;
  logic           src_tick;

  always_comb begin
    unique case (src_i)
      SRC_SYS: src_tick = 1'b1;
      SRC_DIV: src_tick = (div_q == DCW'(DIV - 1));
      SRC_PIN: src_tick = pin_rise_i;
      default: src_tick = 1'b0;
    endcase
  end

  assign tick_o = run_i && src_tick && (pc_q == ps_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      pc_q  <= '0;
    end else if (!run_i) begin
      div_q <= '0;
      pc_q  <= '0;
    end else begin
      div_q <= div_q + 1'b1;
      if (src_tick) pc_q <= (pc_q == ps_i) ? '0 : pc_q + 1'b1;
    end
  end
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          tick_i,
  input  logic [DW-1:0] ref_i,
  input  logic          restart_i,
  input  logic          toggle_i,
  output logic [DW-1:0] cnt_o,
  output logic          match_o,
  output logic          tout_o
);
  logic [DW-1:0] cnt_q;
  logic          tout_q;

  assign match_o = tick_i && (cnt_q == ref_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tout_q <= 1'b1;
    end else if (!run_i) begin
      cnt_q  <= '0;
      tout_q <= 1'b1;
    end else begin
      if (tick_i) cnt_q <= (match_o && restart_i) ? '0 : cnt_q + 1'b1;
      if (toggle_i) tout_q <= tout_q ^ match_o;
      else          tout_q <= !match_o;
    end
  end

  assign cnt_o  = cnt_q;
  assign tout_o = tout_q;
endmodule

// File: rtl/cap_timer.sv
module cap_timer
  import cap_timer_pkg::*;
#(
  parameter int unsigned DW   = 16,
  parameter int unsigned AW   = 3,
  parameter int unsigned DIV  = 16,
  parameter int unsigned SYNC = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic          ext_clk_i,
  input  logic          cap_i,
  output logic          tout_o,
  output logic          irq_o
);
  localparam int unsigned PSW = $bits(mode_t) - 8;

  mode_t         mode_q;
  logic [DW-1:0] ref_q, cap_q, cnt_w;
  logic [1:0]    ev_q;
  logic          ext_lvl, ext_prv, cap_lvl, cap_prv;
  logic          tick, match, cap_hit;
  logic          wr_mode, wr_ref, wr_evt;

  tmr_sync #(.STAGES(SYNC)) u_ext_sync (
    .clk_i, .rst_ni, .d_i(ext_clk_i), .lvl_o(ext_lvl), .prv_o(ext_prv)
  );
  tmr_sync #(.STAGES(SYNC)) u_cap_sync (
    .clk_i, .rst_ni, .d_i(cap_i), .lvl_o(cap_lvl), .prv_o(cap_prv)
  );

  tmr_tick_gen #(.PSW(PSW), .DIV(DIV)) u_tick (
    .clk_i, .rst_ni,
    .run_i(mode_q.run), .src_i(mode_q.src), .ps_i(mode_q.ps),
    .pin_rise_i(ext_lvl && !ext_prv), .tick_o(tick)
  );

  tmr_count #(.DW(DW)) u_cnt (
    .clk_i, .rst_ni,
    .run_i(mode_q.run), .tick_i(tick), .ref_i(ref_q),
    .restart_i(mode_q.restart), .toggle_i(mode_q.toggle),
    .cnt_o(cnt_w), .match_o(match), .tout_o(tout_o)
  );

  always_comb begin
    unique case (mode_q.cap)
      CAP_RISE: cap_hit = cap_lvl && !cap_prv;
      CAP_FALL: cap_hit = !cap_lvl && cap_prv;
      CAP_BOTH: cap_hit = cap_lvl ^ cap_prv;
      default:  cap_hit = 1'b0;
    endcase
  end

  assign wr_mode = wr_en_i && (addr_i == AW'(OFS_MODE));
  assign wr_ref  = wr_en_i && (addr_i == AW'(OFS_REF));
  assign wr_evt  = wr_en_i && (addr_i == AW'(OFS_EVT));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      ref_q  <= '1;
      cap_q  <= '0;
      ev_q   <= '0;
    end else begin
      if (wr_mode) mode_q <= mode_t'(wdata_i[15:0]);
      if (wr_ref)  ref_q  <= wdata_i;
      if (cap_hit) cap_q  <= cnt_w;
      // set wins over write-one-to-clear
      ev_q <= (ev_q & ~(wr_evt ? wdata_i[1:0] : 2'b00)) | {match, cap_hit};
    end
  end

  assign irq_o = (ev_q[1] && mode_q.ref_irq) || (ev_q[0] && (mode_q.cap != CAP_OFF));

  always_comb begin
    unique case (addr_i)
      AW'(OFS_MODE): rdata_o = DW'(mode_q);
      AW'(OFS_REF):  rdata_o = ref_q;
      AW'(OFS_CAP):  rdata_o = cap_q;
      AW'(OFS_CNT):  rdata_o = cnt_w;
      AW'(OFS_EVT):  rdata_o = DW'(ev_q);
      default:       rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/cap_timer_sva.sv
module cap_timer_sva
  import cap_timer_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input mode_t         mode_q,
  input logic [DW-1:0] ref_q,
  input logic [DW-1:0] cnt_w,
  input logic [DW-1:0] cap_q,
  input logic [1:0]    ev_q,
  input logic          tout_o,
  input logic          irq_o
);
  a_r4_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_q.run |=> (cnt_w == '0 && tout_o));

  a_r7_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_w != $past(cnt_w)) |-> (cnt_w == $past(cnt_w) + 1'b1 || cnt_w == '0));

  a_r7_match_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ev_q[1]) |-> $past(cnt_w == ref_q));

  a_r9_capture_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_q != $past(cap_q)) |-> ev_q[0]);

  a_r11_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_q == 2'b00) |-> !irq_o);
endmodule

bind cap_timer cap_timer_sva #(.DW(DW)) u_sva (
  .clk_i(clk_i), .rst_ni(rst_ni), .mode_q(mode_q), .ref_q(ref_q),
  .cnt_w(cnt_w), .cap_q(cap_q), .ev_q(ev_q), .tout_o(tout_o), .irq_o(irq_o)
);

// File: tb/cap_timer_tb.sv
`timescale 1ns/1ps
module cap_timer_tb;
  logic        clk_i = 0, rst_ni = 0, wr_en_i = 0, ext_clk_i = 0, cap_i = 0;
  logic [2:0]  addr_i = 0;
  logic [15:0] wdata_i = 0;
  logic [15:0] rdata_o;
  logic        tout_o, irq_o;
  int total = 0, bad = 0;
  bit done = 0;
  string tag = "R1";

  always #2.5 clk_i = ~clk_i;

  cap_timer u_dut (.*);

  // reference model state
  int m_mode, m_ref, m_cap, m_cnt, m_ev, m_tout, m_pc, m_d16;
  bit [2:0] eh, ch;

  always @(posedge clk_i or negedge rst_ni) begin
    int run, sel, ps, ce, src, tick, match, capev, clr;
    bit er, cr, cf;
    if (!rst_ni) begin
      m_mode = 0; m_ref = 'hFFFF; m_cap = 0; m_cnt = 0; m_ev = 0;
      m_tout = 1; m_pc = 0; m_d16 = 0; eh = 0; ch = 0;
    end else begin
      run = m_mode & 1; sel = (m_mode >> 1) & 3; ps = (m_mode >> 8) & 255;
      ce = (m_mode >> 6) & 3;
      er = eh[1] & ~eh[2]; cr = ch[1] & ~ch[2]; cf = ~ch[1] & ch[2];
      src = (sel == 1) || (sel == 2 && m_d16 == 15) || (sel == 3 && er);
      tick = run && src && (m_pc == ps);
      match = tick && (m_cnt == m_ref);
      capev = (ce == 1 && cr) || (ce == 2 && cf) || (ce == 3 && (cr || cf));
      if (capev) m_cap = m_cnt;
      clr = (wr_en_i && addr_i == 4) ? (wdata_i & 3) : 0;
      m_ev = (m_ev & ~clr) | (match << 1) | capev;
      if (!run) begin
        m_cnt = 0; m_pc = 0; m_d16 = 0; m_tout = 1;
      end else begin
        m_d16 = (m_d16 + 1) % 16;
        if (src) m_pc = (m_pc == ps) ? 0 : (m_pc + 1) % 256;
        if (tick) m_cnt = (match && (m_mode & 8)) ? 0 : (m_cnt + 1) % 65536;
        if (m_mode & 32) m_tout = match ? !m_tout : m_tout;
        else             m_tout = !match;
      end
      if (wr_en_i && addr_i == 0) m_mode = wdata_i;
      if (wr_en_i && addr_i == 1) m_ref = wdata_i;
      eh = {eh[1:0], ext_clk_i};
      ch = {ch[1:0], cap_i};
    end
  end

  task automatic chk(string t, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", t, what, act, exp);
    end
  endtask

  function automatic int exp_rd(int a);
    case (a)
      0: return m_mode; 1: return m_ref; 2: return m_cap;
      3: return m_cnt;  4: return m_ev;  default: return 0;
    endcase
  endfunction

  // compare every clock
  always @(negedge clk_i) if (rst_ni) begin
    chk(tag, "rdata", 32'(rdata_o), exp_rd(int'(addr_i)));
    chk(tag, "tout", 32'(tout_o), m_tout);
    // R11 interrupt combination
    chk(tag, "irq", 32'(irq_o),
        (((m_ev >> 1) & 1) && (m_mode & 16)) || ((m_ev & 1) && ((m_mode >> 6) & 3)));
  end

  task automatic idle(int n);
    repeat (n) begin @(negedge clk_i); #1; end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk_i); #1;
    wr_en_i = 1; addr_i = 3'(a); wdata_i = 16'(d);
    @(negedge clk_i); #1;
    wr_en_i = 0;
  endtask

  task automatic look(int a, int exp, string t);
    @(negedge clk_i); #1;
    addr_i = 3'(a);
    #0.5 chk(t, "read", 32'(rdata_o), exp);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(3); rst_ni = 1;
    tag = "R1";
    look(0, 'h0000, "R1"); look(1, 'hFFFF, "R1"); look(2, 0, "R1");
    look(3, 0, "R1"); look(4, 0, "R1");
    chk("R1", "tout", 32'(tout_o), 1); chk("R1", "irq", 32'(irq_o), 0);
    tag = "R2";
    for (int a = 5; a < 8; a++) look(a, 0, "R2");
    tag = "R3";
    wr(2, 'h1234); wr(3, 'hABCD);
    look(2, 0, "R3"); look(3, 0, "R3");
    tag = "R5"; // sys clock
    wr(0, 'h0003); addr_i = 3; idle(20);
    tag = "R6";
    wr(0, 'h0303); idle(30); wr(0, 'h0203); idle(20);
    tag = "R5"; // divided clock, pin clock, stopped
    wr(0, 'h0005); addr_i = 3; idle(70);
    wr(0, 0); wr(0, 'h0007); addr_i = 3;
    tag = "R12";
    for (int i = 0; i < 12; i++) begin ext_clk_i = ~ext_clk_i; idle(3); end
    tag = "R5";
    wr(0, 'h0001); addr_i = 3; idle(10);
    tag = "R4";
    wr(0, 'h0002); addr_i = 3; idle(5);
    look(3, 0, "R4"); chk("R4", "tout", 32'(tout_o), 1);
    tag = "R7"; // restart with pulse output and match irq
    wr(1, 5); wr(0, 'h001B); addr_i = 4; idle(30);
    tag = "R10";
    wr(4, 2); addr_i = 4; idle(2);
    tag = "R7"; // free running
    wr(0, 0); wr(0, 'h0013); addr_i = 3; idle(25);
    tag = "R8"; // toggle output
    wr(0, 0); wr(1, 3); wr(0, 'h003B); addr_i = 3; idle(30);
    wr(0, 'h011B); idle(20);
    tag = "R10";
    wr(4, 3); addr_i = 4; idle(3);
    tag = "R9";
    wr(1, 'hFFFF);
    wr(0, 'h0043); addr_i = 2;
    for (int i = 0; i < 6; i++) begin cap_i = ~cap_i; idle(5); end
    wr(4, 1); wr(0, 'h0083); addr_i = 2;
    for (int i = 0; i < 6; i++) begin cap_i = ~cap_i; idle(4); end
    wr(4, 1); wr(0, 'h00C3); addr_i = 2;
    for (int i = 0; i < 6; i++) begin cap_i = ~cap_i; idle(4); end
    tag = "R11"; // flag left set, capture interrupt disabled
    wr(0, 'h0003); addr_i = 4; idle(5);
    wr(4, 3); idle(3);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule